// File: doc/BRIEF.md
# Multi-channel event timer comparator

The block holds one 64-bit main counter and a set of comparator channels that software reaches through a flat register space of 32-bit words. Software clears the counter while it is stopped and then starts it with the global run bit. Each channel compares its comparator against the counter. On a match it raises a one-cycle event, either once or again each time a programmed period elapses.

Each channel event goes out on exactly one path. A channel normally pulses its own wired interrupt line. A channel that can deliver messages, and has delivery enabled, instead emits a one-cycle strobe that carries its programmed data and address words. When the global legacy bit is set, channels 0 and 1 are taken over by two fixed legacy lines, a system-tick line and a real-time-clock line.

Register map (byte offsets): capability 0x000, global config 0x010 (bit0 run, bit1 legacy), counter low 0x020 and high 0x024. Channel n sits at 0x100 + 0x20·n, with config at +0x0, comparator low at +0x8, comparator high at +0xC, message data at +0x10 and message address at +0x14. Channel config bits: 0 enable, 1 periodic, 2 set-value, 3 32-bit compare, 4 delivery enable, 8 periodic-capable (read only), 9 message-capable (read only).

Top module: `evt_timer_top`

## Requirements
- R1: The capability word reads the channel count minus one in bits 4:0, a 1 in bit 8 (legacy routing supported) and the constant PERIOD_ID in bits 31:16. All other bits read 0.
- R2: Writes to counter low (0x020) and counter high (0x024) take effect only while the run bit is 0. While the counter runs they are ignored.
- R3: The counter holds while run is 0. Once run is written to 1 at a clock edge, the counter reads its previous value plus the number of edges since that write.
- R4: A one-shot channel (enable=1, periodic=0) pulses its output once, in the cycle in which the counter reads comparator+1, and never again while the comparator is unchanged.
- R5: Writing a channel config with the set-value bit set makes the next comparator-low write load the match value. That write clears the set-value bit, which reads back as 1 while it is pending.
- R6: A periodic channel fires at comparator+1 and then at each further step of the period. After the set-value step is consumed, every comparator write loads only the period and leaves the match value unchanged.
- R7: With the 32-bit compare bit set, only the low 32 bits of the counter and the comparator are compared. With it clear, all 64 bits must match.
- R8: With the legacy bit set, channel 0 events appear only on legacy_tmr_o and channel 1 events only on legacy_rtc_o. irq_o[0] and irq_o[1] stay low.
- R9: A channel with MSG_CAP set and delivery enabled emits msg_vld_o with its data and address words on the match and leaves its irq_o line low. On a channel without the capability the delivery bit is ignored and the wired line fires.
- R10: A channel whose enable bit is 0 produces no interrupt, legacy pulse or message.
- R11: Bits 8 and 9 of a channel config read the channel's periodic and message capabilities and ignore writes. The periodic and delivery bits read 0 on a channel that lacks the capability.
- R12: When several messages are due at once, the lowest-numbered channel is sent first. The others are held and sent on later cycles, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | NCH | Per-channel wired interrupt pulses |
| legacy_tmr_o | output | 1 | Legacy system-tick pulse (channel 0) |
| legacy_rtc_o | output | 1 | Legacy RTC pulse (channel 1) |
| msg_vld_o | output | 1 | Message strobe |
| msg_data_o | output | 32 | Message data word |
| msg_addr_o | output | 32 | Message address word |

## Verification
The in-line properties watch the following on every cycle:
- the counter holding or stepping by one according to the run state, write or no write;
- the set-value flag being consumed by a comparator write;
- the periodic comparator advancing by exactly the period;
- the comparator standing still after a one-shot match;
- legacy routing keeping the two wired lines quiet;
- a single message grant per cycle;
- every interrupt pulse being traced back to an enabled channel.

Only the bench's scenarios can show the absolute event times: the comparator+1 cycle, the spacing of periodic events, the period-only rewrite, the 32-bit versus 64-bit compare difference, the message words and their order, and the capability bits.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int OFF_CAP    = 'h000;
  localparam int OFF_GCFG   = 'h010;
  localparam int OFF_CNT_LO = 'h020;
  localparam int OFF_CNT_HI = 'h024;
  localparam int CH_BASE    = 'h100;
  localparam int CH_STRIDE  = 'h020;
  localparam int CO_CFG     = 'h00;
  localparam int CO_CMP_LO  = 'h08;
  localparam int CO_CMP_HI  = 'h0C;
  localparam int CO_MDAT    = 'h10;
  localparam int CO_MADR    = 'h14;
  localparam int CB_EN  = 0;
  localparam int CB_PER = 1;
  localparam int CB_SV  = 2;
  localparam int CB_M32 = 3;
  localparam int CB_DLV = 4;
endpackage

// File: rtl/evt_main_ctr.sv
module evt_main_ctr (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] cnt_o
);
  logic [63:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 64'd1;
    else if (wr_lo_i) cnt_q[31:0] <= wdata_i;
    else if (wr_hi_i) cnt_q[63:32] <= wdata_i;
  end

  assign cnt_o = cnt_q;

  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !wr_lo_i && !wr_hi_i |=> $stable(cnt_q)); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> cnt_q == $past(cnt_q) + 64'd1); // R2
endmodule

// File: rtl/evt_chan.sv
module evt_chan import evt_pkg::*; #(
  parameter bit PER_CAP = 1'b1,
  parameter bit MSG_CAP = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic [63:0] cnt_i,
  input  logic [31:0] wdata_i,
  input  logic        wr_cfg_i,
  input  logic        wr_cmp_lo_i,
  input  logic        wr_cmp_hi_i,
  input  logic        wr_mdat_i,
  input  logic        wr_madr_i,
  output logic [31:0] cfg_o,
  output logic [63:0] cmp_o,
  output logic [31:0] mdat_o,
  output logic [31:0] madr_o,
  output logic        fire_o,
  output logic        dlv_o
);
  logic        en_q, per_q, sv_q, m32_q, dlv_q;
  logic [63:0] cmp_q, prd_q;
  logic [31:0] mdat_q, madr_q;
  logic        match, to_cmp;

  assign match  = m32_q ? (cnt_i[31:0] == cmp_q[31:0]) : (cnt_i == cmp_q);
  assign fire_o = run_i & en_q & match;
  assign to_cmp = sv_q | ~per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {en_q, per_q, sv_q, m32_q, dlv_q} <= '0;
      cmp_q  <= '0;
      prd_q  <= '0;
      mdat_q <= '0;
      madr_q <= '0;
    end else begin
      if (fire_o && per_q) cmp_q <= cmp_q + prd_q;
      if (wr_cfg_i) begin
        en_q  <= wdata_i[CB_EN];
        per_q <= PER_CAP & wdata_i[CB_PER];
        sv_q  <= wdata_i[CB_SV];
        m32_q <= wdata_i[CB_M32];
        dlv_q <= MSG_CAP & wdata_i[CB_DLV];
      end
      if (wr_cmp_lo_i) begin
        if (to_cmp) cmp_q[31:0] <= wdata_i;
        else        prd_q[31:0] <= wdata_i;
        sv_q <= 1'b0;
      end
      if (wr_cmp_hi_i) begin
        if (to_cmp) cmp_q[63:32] <= wdata_i;
        else        prd_q[63:32] <= wdata_i;
      end
      if (wr_mdat_i) mdat_q <= wdata_i;
      if (wr_madr_i) madr_q <= wdata_i;
    end
  end

  assign cfg_o  = {22'd0, MSG_CAP, PER_CAP, 3'd0, dlv_q, m32_q, sv_q, per_q, en_q};
  assign cmp_o  = cmp_q;
  assign mdat_o = mdat_q;
  assign madr_o = madr_q;
  assign dlv_o  = dlv_q;

  AST_SV_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sv_q && wr_cmp_lo_i |=> !sv_q); // R5
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !per_q && !wr_cmp_lo_i && !wr_cmp_hi_i |=> $stable(cmp_q)); // R4
  AST_PERIOD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && per_q && !wr_cmp_lo_i && !wr_cmp_hi_i
      |=> cmp_q == $past(cmp_q) + $past(prd_q)); // R6
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top import evt_pkg::*; #(
  parameter int              NCH       = 3,
  parameter int              AW        = 12,
  parameter logic [NCH-1:0]  PER_CAP   = 3'b011,
  parameter logic [NCH-1:0]  MSG_CAP   = 3'b110,
  parameter logic [15:0]     PERIOD_ID = 16'h0A3D
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  output logic [NCH-1:0] irq_o,
  output logic           legacy_tmr_o,
  output logic           legacy_rtc_o,
  output logic           msg_vld_o,
  output logic [31:0]    msg_data_o,
  output logic [31:0]    msg_addr_o
);
  localparam int SL = $clog2(CH_STRIDE);
  localparam logic [AW-1:0] CH_END_REL = AW'(NCH * CH_STRIDE);

  logic           run_q, leg_q, wr;
  logic [63:0]    cnt;
  logic [AW-1:0]  ch_rel;
  logic           ch_hit;
  logic [SL-1:0]  ch_off;
  logic [NCH-1:0] ch_sel, fire_w, dlv_w, en_w, msg_path, irq_d;
  logic [NCH-1:0] pend_q, req_v, grant, irq_q;
  logic [31:0]    cfg_w  [NCH];
  logic [63:0]    cmp_w  [NCH];
  logic [31:0]    mdat_w [NCH];
  logic [31:0]    madr_w [NCH];
  logic [31:0]    md_sel, ma_sel;
  logic           ltmr_q, lrtc_q, mvld_q;
  logic [31:0]    mdat_q, madr_q;

  assign wr     = req_i & we_i;
  assign ch_rel = addr_i - AW'(CH_BASE);
  assign ch_hit = (addr_i >= AW'(CH_BASE)) && (ch_rel < CH_END_REL);
  assign ch_off = ch_rel[SL-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr && addr_i == AW'(OFF_GCFG)) begin
      run_q <= wdata_i[0];
      leg_q <= wdata_i[1];
    end
  end

  evt_main_ctr u_ctr (
    .clk_i, .rst_ni,
    .run_i   (run_q),
    .wr_lo_i (wr && addr_i == AW'(OFF_CNT_LO)),
    .wr_hi_i (wr && addr_i == AW'(OFF_CNT_HI)),
    .wdata_i,
    .cnt_o   (cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic is_leg;
    assign ch_sel[i] = ch_hit && (ch_rel[AW-1:SL] == (AW-SL)'(i));
    evt_chan #(.PER_CAP(PER_CAP[i]), .MSG_CAP(MSG_CAP[i])) u_chan (
      .clk_i, .rst_ni,
      .run_i       (run_q),
      .cnt_i       (cnt),
      .wdata_i,
      .wr_cfg_i    (wr && ch_sel[i] && ch_off == SL'(CO_CFG)),
      .wr_cmp_lo_i (wr && ch_sel[i] && ch_off == SL'(CO_CMP_LO)),
      .wr_cmp_hi_i (wr && ch_sel[i] && ch_off == SL'(CO_CMP_HI)),
      .wr_mdat_i   (wr && ch_sel[i] && ch_off == SL'(CO_MDAT)),
      .wr_madr_i   (wr && ch_sel[i] && ch_off == SL'(CO_MADR)),
      .cfg_o       (cfg_w[i]),
      .cmp_o       (cmp_w[i]),
      .mdat_o      (mdat_w[i]),
      .madr_o      (madr_w[i]),
      .fire_o      (fire_w[i]),
      .dlv_o       (dlv_w[i])
    );
    assign en_w[i]     = cfg_w[i][CB_EN];
    assign is_leg      = leg_q && (i < 2);
    assign msg_path[i] = dlv_w[i] && !is_leg;
    assign irq_d[i]    = fire_w[i] && !msg_path[i] && !is_leg;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> $past(en_w[i])); // R10
  end

  // messages: lowest channel first, the rest wait
  assign req_v = (pend_q & en_w) | (fire_w & msg_path);
  assign grant = req_v & (~req_v + NCH'(1));

  always_comb begin
    md_sel = '0;
    ma_sel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        md_sel = mdat_w[i];
        ma_sel = madr_w[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      irq_q  <= '0;
      ltmr_q <= 1'b0;
      lrtc_q <= 1'b0;
      mvld_q <= 1'b0;
      mdat_q <= '0;
      madr_q <= '0;
    end else begin
      pend_q <= req_v & ~grant & en_w;
      irq_q  <= irq_d;
      ltmr_q <= leg_q & fire_w[0];
      lrtc_q <= leg_q & fire_w[1];
      mvld_q <= |req_v;
      if (|req_v) begin
        mdat_q <= md_sel;
        madr_q <= ma_sel;
      end
    end
  end

  assign irq_o        = irq_q;
  assign legacy_tmr_o = ltmr_q;
  assign legacy_rtc_o = lrtc_q;
  assign msg_vld_o    = mvld_q;
  assign msg_data_o   = mdat_q;
  assign msg_addr_o   = madr_q;

  always_comb begin
    rdata_o = '0;
    if (ch_hit) begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_sel[i]) begin
          case (ch_off)
            SL'(CO_CFG):    rdata_o = cfg_w[i];
            SL'(CO_CMP_LO): rdata_o = cmp_w[i][31:0];
            SL'(CO_CMP_HI): rdata_o = cmp_w[i][63:32];
            SL'(CO_MDAT):   rdata_o = mdat_w[i];
            SL'(CO_MADR):   rdata_o = madr_w[i];
            default:        rdata_o = '0;
          endcase
        end
      end
    end else begin
      case (addr_i)
        AW'(OFF_CAP):    rdata_o = {PERIOD_ID, 7'd0, 1'b1, 3'd0, 5'(NCH - 1)};
        AW'(OFF_GCFG):   rdata_o = {30'd0, leg_q, run_q};
        AW'(OFF_CNT_LO): rdata_o = cnt[31:0];
        AW'(OFF_CNT_HI): rdata_o = cnt[63:32];
        default:         rdata_o = '0;
      endcase
    end
  end

  AST_LEGACY_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_q && $past(leg_q) |-> irq_o[1:0] == 2'b00); // R8
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R12
  AST_MSG_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_vld_o |-> $past(|(fire_w | pend_q))); // R9
endmodule

// File: tb/evt_timer_top_tb_top.sv
module evt_timer_top_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0]  irq;
  logic        ltmr, lrtc, mvld;
  logic [31:0] mdata, maddr;

  evt_timer_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .legacy_tmr_o(ltmr),
    .legacy_rtc_o(lrtc), .msg_vld_o(mvld), .msg_data_o(mdata), .msg_addr_o(maddr)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errs = 0, checks = 0, t0 = 0, tr = 0;
  int ev_n [6];
  int ev_t [6][4];
  logic [31:0] md [4];
  logic [31:0] ma [4];
  logic [31:0] v;

  function automatic int chb(int n);
    return 'h100 + 'h20 * n;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    t0 = cyc;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    addr = 12'(a);
    #1 d = rdata;
  endtask

  task automatic start();
    wr('h010, 32'h1);
    tr = t0;
  endtask

  task automatic watch(int n);
    logic [5:0] s;
    for (int k = 0; k < 6; k++) ev_n[k] = 0;
    repeat (n) begin
      @(negedge clk);
      s = {mvld, lrtc, ltmr, irq};
      for (int k = 0; k < 6; k++) begin
        if (s[k]) begin
          if (ev_n[k] < 4) begin
            ev_t[k][ev_n[k]] = cyc - tr;
            if (k == 5) begin
              md[ev_n[k]] = mdata;
              ma[ev_n[k]] = maddr;
            end
          end
          ev_n[k]++;
        end
      end
    end
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    // R1 capability word and reset state
    rd('h000, v); chk("R1 cap", v, 32'h0A3D_0102);
    chk("R1 reset outputs", {26'd0, mvld, lrtc, ltmr, irq}, 32'h0);
    // R3 counter holds while stopped, steps when running
    rd('h020, v); chk("R3 held", v, 0);
    repeat (5) @(negedge clk);
    rd('h020, v); chk("R3 still held", v, 0);
    start();
    repeat (8) @(negedge clk);
    rd('h020, v); chk("R3 advance", v, 32'(cyc - tr));

    // R2 counter writable only when stopped
    do_reset();
    wr('h020, 32'h11); wr('h024, 32'h22);
    rd('h020, v); chk("R2 lo write", v, 32'h11);
    rd('h024, v); chk("R2 hi write", v, 32'h22);
    start();
    wr('h020, 32'h5555);
    rd('h020, v); chk("R2 write ignored while running", v, 32'(32'h11 + cyc - tr));
    rd('h024, v); chk("R2 hi kept", v, 32'h22);

    // R4 one-shot on channel 2
    do_reset();
    wr(chb(2), 32'h1); wr(chb(2) + 8, 32'd20);
    start(); watch(100);
    chk("R4 one-shot count", ev_n[2], 1);
    chk("R4 one-shot time", ev_t[2][0], 21);

    // R5 R6 periodic with set-value step on channel 0
    do_reset();
    wr(chb(0), 32'h7);
    rd(chb(0), v); chk("R5 set-value pending", v[2], 1);
    wr(chb(0) + 8, 32'd10);
    rd(chb(0), v); chk("R5 set-value consumed", v[2], 0);
    wr(chb(0) + 8, 32'd7);
    rd(chb(0) + 8, v); chk("R5 match value kept", v, 32'd10);
    start(); watch(30);
    chk("R6 periodic count", ev_n[0], 3);
    chk("R6 first", ev_t[0][0], 11);
    chk("R6 second", ev_t[0][1], 18);
    chk("R6 third", ev_t[0][2], 25);

    // R6 later writes update period only
    do_reset();
    wr(chb(0), 32'h7); wr(chb(0) + 8, 32'd10); wr(chb(0) + 8, 32'd7);
    wr(chb(0) + 8, 32'd4);
    rd(chb(0) + 8, v); chk("R6 period-only write", v, 32'd10);
    start(); watch(20);
    chk("R6 new period a", ev_t[0][0], 11);
    chk("R6 new period b", ev_t[0][1], 15);
    chk("R6 new period c", ev_t[0][2], 19);

    // R7 32-bit compare
    do_reset();
    wr('h024, 32'h1); wr(chb(2), 32'h9); wr(chb(2) + 8, 32'd15);
    start(); watch(40);
    chk("R7 low-half match count", ev_n[2], 1);
    chk("R7 low-half match time", ev_t[2][0], 16);
    do_reset();
    wr('h024, 32'h1); wr(chb(2), 32'h1); wr(chb(2) + 8, 32'd15);
    start(); watch(40);
    chk("R7 full-width no match", ev_n[2], 0);

    // R8 legacy routing
    do_reset();
    wr(chb(0), 32'h1); wr(chb(0) + 8, 32'd5);
    wr(chb(1), 32'h1); wr(chb(1) + 8, 32'd9);
    wr('h010, 32'h2); wr('h010, 32'h3); tr = t0;
    watch(30);
    chk("R8 legacy tick time", ev_t[3][0], 6);
    chk("R8 legacy rtc time", ev_t[4][0], 10);
    chk("R8 wired lines quiet", ev_n[0] + ev_n[1], 0);

    // R9 R12 messages, priority by channel number
    do_reset();
    wr(chb(1), 32'h11); wr(chb(1) + 8, 32'd12);
    wr(chb(1) + 'h10, 32'hCAFE_0001); wr(chb(1) + 'h14, 32'h0000_FEE0);
    wr(chb(2), 32'h11); wr(chb(2) + 8, 32'd12);
    wr(chb(2) + 'h10, 32'hCAFE_0002); wr(chb(2) + 'h14, 32'h0000_FEE4);
    start(); watch(30);
    chk("R9 msg count", ev_n[5], 2);
    chk("R12 first msg time", ev_t[5][0], 13);
    chk("R12 first msg data", md[0], 32'hCAFE_0001);
    chk("R9 first msg addr", ma[0], 32'h0000_FEE0);
    chk("R12 second msg time", ev_t[5][1], 14);
    chk("R12 second msg data", md[1], 32'hCAFE_0002);
    chk("R9 wired quiet", ev_n[1] + ev_n[2], 0);
    do_reset();
    wr(chb(0), 32'h11); wr(chb(0) + 8, 32'd6);
    start(); watch(20);
    chk("R9 no-cap channel uses wire", ev_n[0], 1);
    chk("R9 no-cap no msg", ev_n[5], 0);

    // R10 disabled channel silent
    do_reset();
    wr(chb(2), 32'h10); wr(chb(2) + 8, 32'd5);
    wr(chb(0), 32'h6); wr(chb(0) + 8, 32'd5); wr(chb(0) + 8, 32'd3);
    start(); watch(30);
    chk("R10 disabled silent", ev_n[0] + ev_n[2] + ev_n[5], 0);

    // R11 capability bits read-only
    do_reset();
    wr(chb(0), 32'hFFFF_FFFF);
    rd(chb(0), v); chk("R11 ch0 cfg", v, 32'h10F);
    wr(chb(2), 32'hFFFF_FFFF);
    rd(chb(2), v); chk("R11 ch2 cfg", v, 32'h21D);
    wr(chb(1), 32'h0);
    rd(chb(1), v); chk("R11 ch1 caps kept", v, 32'h300);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule